// File: doc/BRIEF.md
# Byte-Stride Peripheral Transfer Sequencer

This block copies a 16-bit or 32-bit data register to, or loads it from, a run of bytes that sit two addresses apart in memory. Spacing the bytes this way places every byte on the same lane of a 16-bit word bus, which suits 8-bit peripherals wired to only one half of the data bus. The effective address is a base address plus a sign-extended 16-bit displacement. On each `start` the block latches the direction, the size, the register value, the base, the displacement and the program-fetch address.

The block runs its accesses over a request/acknowledge word bus. One program-word fetch comes before the data bytes and a second comes after them, and each fetched word is pushed to the prefetch queue. The block then gives a one-cycle completion pulse. On a load, the block also gives the assembled register value with a write enable. Instruction decode and exception handling belong to the surrounding logic.

Top module: `bstride_xfer`

## Requirements
- R1: The first data byte address equals `base_addr` plus `disp` sign-extended to 32 bits, modulo 2^32.
- R2: Before any data byte access, exactly one program-word read (`bus_prog`=1) is made at `prog_addr`, and its returned word appears on `pf_word` with `pf_push` high in its acknowledge cycle.
- R3: A long transfer (`is_long`=1) makes four byte accesses at start address +0, +2, +4 and +6. It carries bits 31:24 first, then 23:16, then 15:8, then 7:0.
- R4: A word transfer (`is_long`=0) makes two byte accesses at start address +0 and +2, carrying bits 15:8 and then bits 7:0.
- R5: Every data access has `bus_byte`=1. Program fetches have `bus_byte`=0 and `bus_write`=0.
- R6: After the last data byte, exactly one more program-word read is made at `prog_addr`+2 and pushed through `pf_push`. `done` is high for exactly one cycle, in the cycle after that read is acknowledged.
- R7: On a store (`to_mem`=1), each byte is driven on both lanes of `bus_wdata` with `bus_write`=1. On a load, each byte is taken from `bus_rdata[15:8]` when the address is even and from `bus_rdata[7:0]` when it is odd, and the bytes fill the result from the high end to the low end.
- R8: A word load returns `{reg_val[31:16], assembled 16 bits}`. A long load returns the four assembled bytes in all 32 bits.
- R9: `result_we` is high only in the `done` cycle of a load. It never rises for a store, and `result` is written only once the last byte has arrived.
- R10: A bus request stays high, with address, direction, type and write data held stable, until `bus_ack` is seen at a clock edge.
- R11: A `start` pulse while a transfer is in progress is ignored. The running access sequence and its data are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| to_mem | input | 1 | 1 = register to memory, 0 = memory to register |
| is_long | input | 1 | 1 = 32-bit transfer, 0 = 16-bit |
| base_addr | input | 32 | Base address register value |
| disp | input | 16 | Signed displacement from the prefetch queue |
| reg_val | input | 32 | Data register value (source, or upper half kept on word load) |
| prog_addr | input | 32 | Address of the next program word to prefetch |
| bus_req | output | 1 | Bus access request |
| bus_addr | output | 32 | Access address |
| bus_write | output | 1 | 1 = write access |
| bus_byte | output | 1 | 1 = byte select, 0 = word select |
| bus_prog | output | 1 | 1 = program-word fetch |
| bus_wdata | output | 16 | Write data, byte replicated on both lanes |
| bus_rdata | input | 16 | Read data |
| bus_ack | input | 1 | Access acknowledge |
| pf_push | output | 1 | Push `pf_word` into the prefetch queue |
| pf_word | output | 16 | Fetched program word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| result_we | output | 1 | Load result write enable |
| result | output | 32 | Load result value |

## Verification
On every cycle, the embedded properties check the handshake hold rule, byte select on data accesses against word select on fetches, and the two-address stride between consecutive data bytes. They also check that a prefetch push comes before the first byte, that `done` follows directly after an acknowledged tail fetch, and that `result_we` appears only with `done`. Only the bench scenarios can show the absolute start address with sign extension and wrap, the most-significant-first byte order on both sides, lane choice for odd addresses, and the preserved upper half on word loads. The same holds for ignoring a mid-transfer `start`. The bench sweeps direction, size, displacement sign and magnitude, and bus wait states.

// File: rtl/bstride_pkg.sv
package bstride_pkg;
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_PF_HEAD = 3'd1,
        PH_DATA    = 3'd2,
        PH_PF_TAIL = 3'd3,
        PH_DONE    = 3'd4
    } phase_e;
endpackage

// File: rtl/bstride_ea.sv
module bstride_ea #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] ea
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        ea       = base + disp_ext;
    end
endmodule

// File: rtl/bstride_lane.sv
module bstride_lane #(
    parameter int BUS_W = 16
) (
    input  logic [$clog2(BUS_W/8)-1:0] sel,
    input  logic [BUS_W-1:0]           rdata,
    input  logic [7:0]                 wbyte,
    output logic [7:0]                 rbyte,
    output logic [BUS_W-1:0]           wdata
);
    localparam int LANES = BUS_W / 8;

    // Lowest address maps to the most significant lane.
    always_comb begin
        rbyte = rdata[(LANES - 1 - int'(sel)) * 8 +: 8];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_rep
        assign wdata[g*8 +: 8] = wbyte;
    end
endmodule

// File: rtl/bstride_xfer.sv
module bstride_xfer
    import bstride_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 32,
    parameter int DISP_W = 16,
    parameter int BUS_W  = 16,
    parameter int STRIDE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              to_mem,
    input  logic              is_long,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DISP_W-1:0] disp,
    input  logic [REG_W-1:0]  reg_val,
    input  logic [ADDR_W-1:0] prog_addr,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic              bus_byte,
    output logic              bus_prog,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic [BUS_W-1:0]  bus_rdata,
    input  logic              bus_ack,
    output logic              pf_push,
    output logic [BUS_W-1:0]  pf_word,
    output logic              busy,
    output logic              done,
    output logic              result_we,
    output logic [REG_W-1:0]  result
);
    localparam int LONG_BYTES = REG_W / 8;
    localparam int WORD_BYTES = REG_W / 16;
    localparam int HALF_W     = REG_W / 2;
    localparam int CNT_W      = $clog2(LONG_BYTES + 1);
    localparam int SEL_W      = $clog2(BUS_W / 8);
    localparam int PC_STEP    = BUS_W / 8;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  left;
        logic              to_mem;
        logic              is_long;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] pc;
        logic [REG_W-1:0]  shreg;
        logic [HALF_W-1:0] keep_hi;
        logic [REG_W-1:0]  result;
    } st_t;

    st_t st_d, st_q;

    logic [ADDR_W-1:0] ea;
    logic [7:0]        rbyte;
    logic [7:0]        wbyte;
    logic [REG_W-1:0]  assembled;

    bstride_ea #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_ea (
        .base (base_addr),
        .disp (disp),
        .ea   (ea)
    );

    assign wbyte = st_q.shreg[REG_W-1 -: 8];

    bstride_lane #(.BUS_W(BUS_W)) u_lane (
        .sel   (st_q.addr[SEL_W-1:0]),
        .rdata (bus_rdata),
        .wbyte (wbyte),
        .rbyte (rbyte),
        .wdata (bus_wdata)
    );

    assign assembled = {st_q.shreg[REG_W-9:0], rbyte};

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase   = PH_PF_HEAD;
                    st_d.to_mem  = to_mem;
                    st_d.is_long = is_long;
                    st_d.addr    = ea;
                    st_d.pc      = prog_addr;
                    st_d.left    = is_long ? CNT_W'(LONG_BYTES) : CNT_W'(WORD_BYTES);
                    st_d.keep_hi = reg_val[REG_W-1:HALF_W];
                    if (to_mem) begin
                        st_d.shreg = is_long ? reg_val : (reg_val << HALF_W);
                    end else begin
                        st_d.shreg = '0;
                    end
                end
            end
            PH_PF_HEAD: begin
                if (bus_ack) begin
                    st_d.pc    = st_q.pc + ADDR_W'(PC_STEP);
                    st_d.phase = PH_DATA;
                end
            end
            PH_DATA: begin
                if (bus_ack) begin
                    st_d.addr  = st_q.addr + ADDR_W'(STRIDE);
                    st_d.left  = st_q.left - CNT_W'(1);
                    st_d.shreg = st_q.to_mem ? (st_q.shreg << 8) : assembled;
                    if (st_q.left == CNT_W'(1)) begin
                        st_d.phase = PH_PF_TAIL;
                        if (!st_q.to_mem) begin
                            st_d.result = st_q.is_long ? assembled
                                                       : {st_q.keep_hi, assembled[HALF_W-1:0]};
                        end
                    end
                end
            end
            PH_PF_TAIL: begin
                if (bus_ack) begin
                    st_d.pc    = st_q.pc + ADDR_W'(PC_STEP);
                    st_d.phase = PH_DONE;
                end
            end
            PH_DONE: begin
                st_d.phase = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_prog  = (st_q.phase == PH_PF_HEAD) || (st_q.phase == PH_PF_TAIL);
        bus_byte  = (st_q.phase == PH_DATA);
        bus_req   = bus_prog || bus_byte;
        bus_write = bus_byte && st_q.to_mem;
        bus_addr  = bus_prog ? st_q.pc : st_q.addr;
        pf_push   = bus_prog && bus_ack;
        pf_word   = bus_rdata;
        busy      = (st_q.phase != PH_IDLE);
        done      = (st_q.phase == PH_DONE);
        result_we = done && !st_q.to_mem;
        result    = st_q.result;
    end

    // R10
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_write)
                                && $stable(bus_prog) && $stable(bus_wdata));

    // R5
    data_byte_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_prog |-> bus_byte);

    // R5
    fetch_word_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_prog |-> !bus_byte && !bus_write);

    // R3 R4
    byte_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && bus_byte && (st_q.left > CNT_W'(1))
        |=> bus_byte && (bus_addr == $past(bus_addr) + ADDR_W'(STRIDE)));

    // R2
    head_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_byte) |-> $past(pf_push));

    // R6
    tail_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pf_push) && !bus_req);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R9
    we_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_we |-> done);
endmodule

// File: tb/tb_bstride_xfer.sv
`timescale 1ns/100ps
module tb_bstride_xfer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        to_mem = 1'b0;
    logic        is_long = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] disp = '0;
    logic [31:0] reg_val = '0;
    logic [31:0] prog_addr = '0;
    logic        bus_req, bus_write, bus_byte, bus_prog;
    logic [31:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        bus_ack = 1'b0;
    logic        pf_push;
    logic [15:0] pf_word;
    logic        busy, done, result_we;
    logic [31:0] result;

    always #2.5 clk = ~clk;

    bstride_xfer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .to_mem(to_mem), .is_long(is_long),
        .base_addr(base_addr), .disp(disp), .reg_val(reg_val), .prog_addr(prog_addr),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_write(bus_write), .bus_byte(bus_byte),
        .bus_prog(bus_prog), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .pf_push(pf_push), .pf_word(pf_word), .busy(busy), .done(done),
        .result_we(result_we), .result(result)
    );

    function automatic logic [15:0] memw(input logic [31:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] + a[7:0] + 8'h11};
    endfunction

    assign bus_rdata = memw(bus_addr);

    int n_chk = 0;
    int n_fail = 0;
    int wait_n = 0;
    int wcnt = 0;
    int n_log = 0;
    logic [31:0] lg_addr [16];
    logic        lg_prog [16];
    logic        lg_write[16];
    logic        lg_byte [16];
    logic [15:0] lg_wdata[16];
    logic        lg_push [16];
    logic [15:0] lg_pf   [16];

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bus responder: decides acknowledge at the falling edge and logs the access.
    always @(negedge clk) begin
        if (bus_req) begin
            if (wcnt >= wait_n) begin
                bus_ack = 1'b1;
                wcnt = 0;
                #1;
                if (n_log < 16) begin
                    lg_addr[n_log]  = bus_addr;
                    lg_prog[n_log]  = bus_prog;
                    lg_write[n_log] = bus_write;
                    lg_byte[n_log]  = bus_byte;
                    lg_wdata[n_log] = bus_wdata;
                    lg_push[n_log]  = pf_push;
                    lg_pf[n_log]    = pf_word;
                end
                n_log++;
            end else begin
                bus_ack = 1'b0;
                wcnt++;
            end
        end else begin
            bus_ack = 1'b0;
            wcnt = 0;
        end
    end

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic run_xfer(input logic dir, input logic lng, input logic [31:0] base,
                            input logic [15:0] d, input logic [31:0] rv,
                            input logic [31:0] pc, input int ws, input logic inject);
        logic [31:0] ea;
        logic [31:0] acc;
        logic [31:0] exp_res;
        logic [7:0]  b;
        int nb;
        int cyc;
        ea = base + {{16{d[15]}}, d};
        nb = lng ? 4 : 2;
        wait_n = ws;
        n_log = 0;
        @(negedge clk);
        to_mem = dir; is_long = lng; base_addr = base; disp = d;
        reg_val = rv; prog_addr = pc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            repeat (3) @(negedge clk);
            to_mem = ~dir; is_long = ~lng; base_addr = base ^ 32'h00F0_0F00;
            disp = ~d; reg_val = ~rv; prog_addr = pc + 32'h100; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        #2;
        chk(done, "R6 done reached", {31'd0, done}, 32'd1);
        chk(result_we == !dir, "R9 result_we in done cycle", {31'd0, result_we}, {31'd0, !dir});
        chk(n_log == nb + 2, "R3 R4 access count", n_log, nb + 2);
        acc = '0;
        for (int k = 0; k < nb; k++) begin
            logic [15:0] w;
            w = memw(ea + 32'(2 * k));
            b = ea[0] ? w[7:0] : w[15:8];
            acc = {acc[23:0], b};
        end
        exp_res = lng ? acc : {rv[31:16], acc[15:0]};
        if (!dir) begin
            chk(result == exp_res, lng ? "R8 R7 long load result" : "R8 R7 word load result",
                result, exp_res);
        end
        if (n_log == nb + 2) begin
            chk(lg_prog[0] && !lg_byte[0] && !lg_write[0], "R2 R5 head fetch type",
                {29'd0, lg_prog[0], lg_byte[0], lg_write[0]}, 32'h4);
            chk(lg_addr[0] == pc, "R2 head fetch address", lg_addr[0], pc);
            chk(lg_push[0] && lg_pf[0] == memw(pc), "R2 head push", {15'd0, lg_push[0], lg_pf[0]},
                {16'h0001, memw(pc)});
            for (int k = 0; k < nb; k++) begin
                int i;
                logic [7:0] eb;
                i = k + 1;
                chk(lg_addr[i] == ea + 32'(2 * k), k == 0 ? "R1 start address" : "R3 R4 byte address",
                    lg_addr[i], ea + 32'(2 * k));
                chk(lg_byte[i] && !lg_prog[i] && !lg_push[i] && lg_write[i] == dir,
                    "R5 R7 data access type",
                    {28'd0, lg_byte[i], lg_prog[i], lg_push[i], lg_write[i]},
                    {28'd0, 1'b1, 1'b0, 1'b0, dir});
                if (dir) begin
                    eb = lng ? rv[31 - 8*k -: 8] : rv[15 - 8*k -: 8];
                    chk(lg_wdata[i] == {eb, eb}, "R3 R4 R7 store byte order", lg_wdata[i], {eb, eb});
                end
            end
            chk(lg_prog[nb+1] && !lg_byte[nb+1] && lg_addr[nb+1] == pc + 32'd2,
                "R6 tail fetch", lg_addr[nb+1], pc + 32'd2);
            chk(lg_push[nb+1] && lg_pf[nb+1] == memw(pc + 32'd2), "R6 tail push",
                {15'd0, lg_push[nb+1], lg_pf[nb+1]}, {16'h0001, memw(pc + 32'd2)});
        end
        if (inject) begin
            chk(n_log == nb + 2, "R11 start while busy ignored", n_log, nb + 2);
        end
        @(negedge clk);
        #2;
        chk(!done && !result_we && !busy, "R6 R9 single-cycle done",
            {29'd0, done, result_we, busy}, 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [15:0] dlist [6];
        dlist[0] = 16'h0000; dlist[1] = 16'h0001; dlist[2] = 16'hFFFE;
        dlist[3] = 16'h7FFF; dlist[4] = 16'h8000; dlist[5] = 16'h0006;
        repeat (3) @(negedge clk);
        #1;
        chk(!bus_req && !done && !busy && !result_we, "R10 reset idle",
            {28'd0, bus_req, done, busy, result_we}, 32'd0);
        rst_n = 1'b1;
        for (int dir = 0; dir < 2; dir++) begin
            for (int lng = 0; lng < 2; lng++) begin
                for (int di = 0; di < 6; di++) begin
                    for (int ws = 0; ws < 3; ws += 2) begin
                        logic [31:0] base;
                        logic [31:0] rv;
                        base = (di == 5) ? 32'hFFFF_FFFC : 32'h0000_1230 + 32'(di * 7);
                        rv   = 32'hC3A5_0000 ^ 32'(di * 32'h0101_0101 + lng * 32'h1357 + ws);
                        run_xfer(dir[0], lng[0], base, dlist[di], rv,
                                 32'h0000_4000 + 32'(di * 16), ws, (di == 0) && (ws == 2));
                    end
                end
            end
        end
        finish_up();
    end
endmodule